// File: doc/BRIEF.md
# Max-Min Fair Rate Allocator

This block divides the capacity of one shared link among a fixed set of flows so that no flow can get more without taking rate from a flow that already has less. Software or a neighbouring block first writes each flow's requested rate into a small request memory, indexed by flow number. It then presents the link capacity and pulses start. A sequential engine settles one flow per step. Each step takes the smallest request still open and grants the lesser of that request and an equal split of the capacity that is left. It then charges the grant against the remaining capacity and moves to the next flow.

Rates are unsigned fixed-point words: 16 bits with 8 fractional bits by default. All arithmetic works on the raw integer codes, so the fractional scaling is only a convention between the writer and the reader. The equal split comes from a multi-cycle restoring divider. When every flow has a grant, the block raises done. Each grant can then be read back by flow index through a registered read port.

Top module: `maxmin_alloc`

## Requirements
- R1: After a synchronous reset, busy and done are both low.
- R2: While the engine is idle or done, a cycle with wr_en high stores wr_rate as the request of flow wr_idx. A write attempted while busy is high is dropped.
- R3: A start pulse accepted while idle or done latches cap as the remaining capacity and sets the open-flow count to NFLOW. busy is high from the next cycle on, and done is low.
- R4: Each step serves the open flow with the smallest request. Among equal requests, the lowest flow index is served first.
- R5: The share for a step is floor(remaining capacity / open-flow count), computed on the raw integer codes. The grant is the request when the request is less than or equal to the share, and the share otherwise.
- R6: After each grant, the remaining capacity drops by the grant and the open-flow count drops by one. The sum of all grants therefore never exceeds cap.
- R7: After the last grant, busy falls and done rises. Done then stays high until the next accepted start.
- R8: A start pulse while busy is high has no effect. The run in progress finishes with the capacity and requests it began with.
- R9: rd_rate shows the grant of flow rd_idx one clock after rd_idx is presented.
- R10: Requests that together fit within the capacity are each granted in full. Requests that all exceed the equal split each receive a floor share. Any remainder from the divisions goes to the flows served last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Request write strobe |
| wr_idx | input | IW | Flow index of the request write |
| wr_rate | input | RW | Requested rate (fixed point) |
| cap | input | RW | Link capacity, sampled at start |
| start | input | 1 | Start-of-computation pulse |
| rd_idx | input | IW | Flow index to read the grant of |
| rd_rate | output | RW | Granted rate of flow rd_idx (registered) |
| busy | output | 1 | Engine computing |
| done | output | 1 | Grants valid; held until the next start |

## Verification
The bench targets equal requests under a capacity that leaves a remainder. If the tie order is wrong, the extra unit lands on the wrong flow. It also runs cases where every request fits, so a design that split the capacity evenly would shrink small grants or inflate large ones. A zero capacity must leave every grant at zero, and a design that subtracts before clamping would wrap and go wrong there. Finally, a second start and a request write are issued during a run. A design that honoured either would restart or change its grants, and both would show in the values read back.

// File: rtl/maxmin_pkg.sv
package maxmin_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_DIV,
    ST_GRANT,
    ST_DONE
  } eng_state_t;
endpackage

// File: rtl/mm_sdp_ram.sv
// Simple dual-port memory, one write port and one registered read port.
module mm_sdp_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mm_restoring_div.sv
// Unsigned restoring divider: one quotient bit per cycle, NW cycles per divide.
module mm_restoring_div #(
  parameter int NW = 16,
  parameter int DW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [NW-1:0] quo,
  output logic          done_p
);
  localparam int KW = $clog2(NW + 1);

  logic [NW-1:0] q;
  logic [DW-1:0] r, dvr;
  logic [KW-1:0] n;
  logic          run;
  logic [DW:0]   shifted, trial;

  assign shifted = {r, q[NW-1]};
  assign trial   = shifted - {1'b0, dvr};
  assign quo     = q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0; r <= '0; dvr <= '0; n <= '0; run <= 1'b0; done_p <= 1'b0;
    end else begin
      done_p <= 1'b0;
      if (start) begin
        q   <= dividend;
        r   <= '0;
        dvr <= divisor;
        n   <= KW'(NW);
        run <= 1'b1;
      end else if (run) begin
        if (shifted >= {1'b0, dvr}) begin
          r <= trial[DW-1:0];
          q <= {q[NW-2:0], 1'b1};
        end else begin
          r <= shifted[DW-1:0];
          q <= {q[NW-2:0], 1'b0};
        end
        n <= n - 1'b1;
        if (n == KW'(1)) begin
          run    <= 1'b0;
          done_p <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/maxmin_alloc.sv
module maxmin_alloc #(
  parameter int NFLOW = 4,
  parameter int RW    = 16,
  localparam int IW   = (NFLOW > 1) ? $clog2(NFLOW) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [RW-1:0] wr_rate,
  input  logic [RW-1:0] cap,
  input  logic          start,
  input  logic [IW-1:0] rd_idx,
  output logic [RW-1:0] rd_rate,
  output logic          busy,
  output logic          done
);
  import maxmin_pkg::*;

  localparam int CW = $clog2(NFLOW + 1);
  localparam int PW = IW + 1;
  localparam logic [PW-1:0] NF_P = PW'(NFLOW);
  localparam logic [CW-1:0] NF_C = CW'(NFLOW);

  eng_state_t     state;
  logic [PW-1:0]  ptr;
  logic           pv;
  logic [IW-1:0]  pidx;
  logic [NFLOW-1:0] alloc;
  logic [RW-1:0]  best_val;
  logic [IW-1:0]  best_idx;
  logic           found;
  logic [RW-1:0]  rem_cap;
  logic [CW-1:0]  rem_cnt;
  logic [RW-1:0]  req_rdata;
  logic [RW-1:0]  share;
  logic           dv_start, dv_done;
  logic           grant_we;
  logic [RW-1:0]  grant_val;
  logic           accept;
  logic           req_we;

  assign accept    = start && (state == ST_IDLE || state == ST_DONE);
  assign req_we    = wr_en && !busy;
  assign grant_we  = (state == ST_GRANT);
  assign grant_val = (best_val <= share) ? best_val : share;

  mm_sdp_ram #(.DW(RW), .DEPTH(NFLOW)) u_req (
    .clk(clk), .we(req_we), .waddr(wr_idx), .wdata(wr_rate),
    .raddr(ptr[IW-1:0]), .rdata(req_rdata)
  );

  mm_sdp_ram #(.DW(RW), .DEPTH(NFLOW)) u_grant (
    .clk(clk), .we(grant_we), .waddr(best_idx), .wdata(grant_val),
    .raddr(rd_idx), .rdata(rd_rate)
  );

  mm_restoring_div #(.NW(RW), .DW(CW)) u_div (
    .clk(clk), .rst(rst), .start(dv_start), .dividend(rem_cap),
    .divisor(rem_cnt), .quo(share), .done_p(dv_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      alloc    <= '0;
      ptr      <= '0;
      pv       <= 1'b0;
      pidx     <= '0;
      found    <= 1'b0;
      best_val <= '0;
      best_idx <= '0;
      rem_cap  <= '0;
      rem_cnt  <= '0;
      dv_start <= 1'b0;
    end else begin
      dv_start <= 1'b0;
      case (state)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            rem_cap <= cap;
            rem_cnt <= NF_C;
            alloc   <= '0;
            busy    <= 1'b1;
            done    <= 1'b0;
            ptr     <= '0;
            pv      <= 1'b0;
            found   <= 1'b0;
            state   <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          // Linear scan: address issued one cycle, data compared the next.
          if (ptr < NF_P) begin
            ptr  <= ptr + 1'b1;
            pv   <= 1'b1;
            pidx <= ptr[IW-1:0];
          end else begin
            pv <= 1'b0;
          end
          if (pv && !alloc[pidx] && (!found || req_rdata < best_val)) begin
            best_val <= req_rdata;
            best_idx <= pidx;
            found    <= 1'b1;
          end
          if (ptr == NF_P && !pv) begin
            dv_start <= 1'b1;
            state    <= ST_DIV;
          end
        end
        ST_DIV: begin
          if (dv_done) state <= ST_GRANT;
        end
        ST_GRANT: begin
          rem_cap         <= rem_cap - grant_val;
          rem_cnt         <= rem_cnt - 1'b1;
          alloc[best_idx] <= 1'b1;
          if (rem_cnt == CW'(1)) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_DONE;
          end else begin
            ptr   <= '0;
            found <= 1'b0;
            state <= ST_SCAN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/maxmin_alloc_chk.sv
module maxmin_alloc_chk #(
  parameter int RW = 16,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          grant_we,
  input logic [RW-1:0] grant_val,
  input logic [RW-1:0] rem_cap,
  input logic [CW-1:0] rem_cnt
);
  // R7: busy and done are never high together
  p_done_excl_r7: assert property (@(posedge clk) disable iff (rst) !(busy && done));

  // R7: done holds until a start arrives
  p_done_hold_r7: assert property (@(posedge clk) disable iff (rst) done && !start |=> done);

  // R3: accepted start raises busy on the next cycle
  p_start_busy_r3: assert property (@(posedge clk) disable iff (rst) !busy && start |=> busy);

  // R8: start during a run does not drop busy or restart the count
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    busy && start && !grant_we |=> busy && $stable(rem_cnt));

  // R6: a grant never exceeds what is left of the capacity
  p_grant_fits_r6: assert property (@(posedge clk) disable iff (rst) grant_we |-> grant_val <= rem_cap);

  // R6: each grant removes exactly one open flow and its grant from the capacity
  p_count_dec_r6: assert property (@(posedge clk) disable iff (rst)
    grant_we |=> rem_cnt == $past(rem_cnt) - 1'b1 && rem_cap == $past(rem_cap) - $past(grant_val));
endmodule

bind maxmin_alloc maxmin_alloc_chk #(.RW(RW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .grant_we(grant_we), .grant_val(grant_val), .rem_cap(rem_cap), .rem_cnt(rem_cnt)
);

// File: tb/sim_maxmin_alloc.sv
`timescale 1ns/1ps
module sim_maxmin_alloc;
  localparam int NF = 4;
  localparam int RW = 16;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [RW-1:0] wr_rate = '0;
  logic [RW-1:0] cap = '0;
  logic          start = 1'b0;
  logic [IW-1:0] rd_idx = '0;
  logic [RW-1:0] rd_rate;
  logic          busy, done;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [RW-1:0] req_m [NF];
  logic [RW-1:0] exp_m [NF];

  always #5 clk = ~clk;

  maxmin_alloc #(.NFLOW(NF), .RW(RW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_rate(wr_rate),
    .cap(cap), .start(start), .rd_idx(rd_idx), .rd_rate(rd_rate),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Model from R4/R5/R6: smallest open request first, lowest index on ties,
  // floor share of what is left.
  task automatic ref_calc(input logic [RW-1:0] c);
    int remc = c;
    bit used [NF];
    for (int i = 0; i < NF; i++) used[i] = 1'b0;
    for (int cnt = NF; cnt > 0; cnt--) begin
      int bi = -1;
      int sh, g;
      for (int i = 0; i < NF; i++)
        if (!used[i] && (bi < 0 || req_m[i] < req_m[bi])) bi = i;
      sh = remc / cnt;
      g  = (req_m[bi] <= sh) ? int'(req_m[bi]) : sh;
      exp_m[bi] = RW'(g);
      used[bi] = 1'b1;
      remc -= g;
    end
  endtask

  task automatic write_req(input int idx, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_rate = RW'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_all();
    for (int i = 0; i < NF; i++) write_req(i, int'(req_m[i]));
  endtask

  task automatic kick(input int c);
    @(negedge clk);
    cap = RW'(c); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(done === 1'b1, tag, int'(done), 1);
  endtask

  task automatic read_chk(input string tag, input int c);
    int sum = 0;
    for (int i = 0; i < NF; i++) begin
      @(negedge clk);
      rd_idx = IW'(i);
      @(negedge clk);
      chk(rd_rate === exp_m[i], tag, int'(rd_rate), int'(exp_m[i]));
      sum += int'(rd_rate);
    end
    chk(sum <= c, "R6 sum of grants within capacity", sum, c);
  endtask

  task automatic run_case(input int c, input string tag);
    load_all();
    ref_calc(RW'(c));
    kick(c);
    chk(busy === 1'b1 && done === 1'b0, "R3 busy after start", int'(busy), 1);
    wait_done("R7 done raised");
    chk(busy === 1'b0, "R7 busy low at done", int'(busy), 0);
    read_chk(tag, c);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        chk(1'b0, "watchdog expired", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(done === 1'b0, "R1 done after reset", int'(done), 0);

    // R5 R10: canonical water-filling case, cap 1.0, requests 0.1 0.5 10 5
    req_m[0] = 16'd26; req_m[1] = 16'd128; req_m[2] = 16'd2560; req_m[3] = 16'd1280;
    run_case(256, "R5 R9 canonical grants");

    // R4: equal requests, remainder goes to highest index (served last)
    for (int i = 0; i < NF; i++) req_m[i] = 16'd5000;
    run_case(1001, "R4 tie order grants");

    // R10: all requests fit
    req_m[0] = 16'd10; req_m[1] = 16'd0; req_m[2] = 16'd300; req_m[3] = 16'd50;
    run_case(2000, "R10 all fit grants");

    // R6: zero capacity gives zero grants
    run_case(0, "R6 zero capacity grants");

    // R7: done holds without start
    repeat (20) @(negedge clk);
    chk(done === 1'b1, "R7 done held", int'(done), 1);

    // R8 R2: start and write during a run are ignored
    req_m[0] = 16'd700; req_m[1] = 16'd90; req_m[2] = 16'd400; req_m[3] = 16'd900;
    load_all();
    ref_calc(16'd1500);
    kick(1500);
    repeat (3) @(negedge clk);
    cap = 16'd9; start = 1'b1; wr_en = 1'b1; wr_idx = 2'd1; wr_rate = 16'd1;
    @(negedge clk);
    start = 1'b0; wr_en = 1'b0;
    chk(busy === 1'b1, "R8 still busy after ignored start", int'(busy), 1);
    wait_done("R8 run completes");
    read_chk("R8 R2 grants unaffected", 1500);
    // R2: the dropped write must not have reached the request memory
    kick(1500);
    wait_done("R2 rerun done");
    read_chk("R2 request kept after busy write", 1500);

    // Random runs
    for (int t = 0; t < 30; t++) begin
      int c;
      for (int i = 0; i < NF; i++)
        req_m[i] = RW'((t % 3 == 0) ? $urandom_range(0, 8) : $urandom_range(0, 3000));
      c = $urandom_range(0, 6000);
      run_case(c, "R5 random grants");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule